// File: doc/BRIEF.md
# Requester ID Range Translator

This block turns a 16-bit PCIe Requester ID into two values: the index of the IOMMU that serves the requester, and a sideband specifier for that IOMMU. The RID is laid out with the bus number in bits [15:8], the device number in bits [7:3] and the function number in bits [2:0]. The block first ANDs the RID with a programmable global mask. It then checks the result against a small table of half-open ranges. On a match the specifier is rebased to (masked RID − range base + output base), using 16-bit wrap-around arithmetic.

Software loads the table through a configuration port. One strobe writes the mask. A second strobe writes a complete entry in a single cycle: the entry's valid bit, RID base, target index, output base and a 17-bit length. The length is 17 bits wide so that a range can span all 0x10000 RIDs. One table can express several mappings:
- an identity map (one entry covering everything);
- function-blind specifiers (mask 0xfff8, which clears the function bits);
- a flipped top bit (two half-space entries with swapped output bases);
- a split of buses across several IOMMUs.

Lookups arrive one per cycle with a valid flag. Each result is registered and appears in the cycle after the request is accepted, in request order.

Top module: `rid_xlate`

## Requirements
- R1: After reset no result is presented. Every entry is invalid, so the first lookup misses. The mask resets to 0xffff, so RID bits pass unchanged.
- R2: The incoming RID is ANDed with the mask before both the range compare and the specifier arithmetic. For example, with mask 0xfff8 and an identity entry, RID 0xabcf yields specifier 0xabc8.
- R3: An entry matches the masked RID r only when base <= r < base + length. A RID equal to base + length misses that entry.
- R4: On a hit the specifier is (r − base + output base) modulo 2^16. With entries {base 0, out 0x8000, len 0x8000} and {base 0x8000, out 0, len 0x8000}, the specifier is the RID with bit 15 inverted.
- R5: An entry with length 0 never matches. An entry with base 0, output base 0 and length 0x10000 maps every RID to itself.
- R6: An entry whose valid bit is clear never matches. On a miss the hit flag is 0, and both the target and the specifier are 0.
- R7: When several valid entries match, the entry with the lowest index supplies the target and the specifier.
- R8: A request accepted at a clock edge produces exactly one result flagged valid after the next edge. Back-to-back requests give results on consecutive cycles in request order. When no result is presented, the hit flag, target and specifier all read 0.
- R9: A table or mask write at the same edge as a request does not affect that request. It takes effect from the next request onward.
- R10: The target reported on a hit is the target field of the winning entry, so different ranges can steer to different IOMMUs. For example, buses 0–127 can go to target 1 and buses 128–255 to target 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaskWr | input | 1 | Strobe: load cfgMask into the global mask |
| cfgMask | input | RID_W | New mask value |
| cfgEntryWr | input | 1 | Strobe: load one complete table entry |
| cfgEntry | input | IDX_W | Index of the entry being written |
| cfgValid | input | 1 | Valid bit of the written entry |
| cfgRidBase | input | RID_W | Range base of the written entry |
| cfgTarget | input | TGT_W | Target IOMMU index of the written entry |
| cfgOutBase | input | RID_W | Output (specifier) base of the written entry |
| cfgLength | input | RID_W+1 | Range length of the written entry |
| reqValid | input | 1 | Lookup request valid |
| reqRid | input | RID_W | Requester ID to look up |
| respValid | output | 1 | Result valid |
| respHit | output | 1 | A valid entry matched |
| respTarget | output | TGT_W | Target IOMMU index; 0 on a miss |
| respSpec | output | RID_W | Sideband specifier; 0 on a miss |

## Verification
Every result is due exactly one clock edge after its request: the edge that accepts a request also registers the answer. A write made at that same edge is only visible to the request that follows. The bench keeps a behavioural model of the mask and the table. At each rising edge the model computes the answer using the table as it stood before any write at that edge, and only then applies the write. At the following falling edge the bench compares the result valid flag on every cycle, and compares the hit flag, target and specifier whenever a result is due. Directed sequences cover the range boundaries, overlapping entries, zero-length and invalid entries, a write and a lookup in the same cycle, and a back-to-back request stream.

// File: rtl/rid_xlate_pkg.sv
package rid_xlate_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic maskWr;   // load global mask
    logic entryWr;  // load one table entry
    logic lookup;   // a request is accepted this edge
  } xlateStrobe_t;
endpackage

// File: rtl/rid_xlate_ctrl.sv
module rid_xlate_ctrl
  import rid_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgMaskWr,
  input  logic         cfgEntryWr,
  input  logic         reqValid,
  output xlateStrobe_t strobe,
  output logic         respValid
);
  always_comb begin
    strobe.maskWr  = cfgMaskWr;
    strobe.entryWr = cfgEntryWr;
    strobe.lookup  = reqValid;
  end

  // One-cycle result pipeline: valid follows accepted request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end
endmodule

// File: rtl/rid_xlate_dp.sv
module rid_xlate_dp
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RID_W       = 16,
  parameter int TGT_W       = 2,
  localparam int LEN_W      = RID_W + 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlateStrobe_t     strobe,
  input  logic [RID_W-1:0] cfgMask,
  input  logic [IDX_W-1:0] cfgEntry,
  input  logic             cfgValid,
  input  logic [RID_W-1:0] cfgRidBase,
  input  logic [TGT_W-1:0] cfgTarget,
  input  logic [RID_W-1:0] cfgOutBase,
  input  logic [LEN_W-1:0] cfgLength,
  input  logic [RID_W-1:0] reqRid,
  output logic             respHit,
  output logic [TGT_W-1:0] respTarget,
  output logic [RID_W-1:0] respSpec
);
  logic [RID_W-1:0] ridMask;
  logic             entValid [NUM_ENTRIES];
  logic [RID_W-1:0] entBase  [NUM_ENTRIES];
  logic [TGT_W-1:0] entTgt   [NUM_ENTRIES];
  logic [RID_W-1:0] entOut   [NUM_ENTRIES];
  logic [LEN_W-1:0] entLen   [NUM_ENTRIES];

  // Table and mask storage; writes land at the edge, so a lookup
  // accepted at the same edge still reads the previous contents.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ridMask <= '1;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entBase[i]  <= '0;
        entTgt[i]   <= '0;
        entOut[i]   <= '0;
        entLen[i]   <= '0;
      end
    end else begin
      if (strobe.maskWr) ridMask <= cfgMask;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.entryWr && (cfgEntry == IDX_W'(i))) begin
          entValid[i] <= cfgValid;
          entBase[i]  <= cfgRidBase;
          entTgt[i]   <= cfgTarget;
          entOut[i]   <= cfgOutBase;
          entLen[i]   <= cfgLength;
        end
      end
    end
  end

  logic [RID_W-1:0]       maskedRid;
  logic [NUM_ENTRIES-1:0] entMatch;

  assign maskedRid = reqRid & ridMask;

  // Parallel half-open range compare, one comparator pair per entry.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [LEN_W-1:0] upperEx;
    logic             lowOk;
    logic             highOk;
    assign upperEx     = {1'b0, entBase[g]} + entLen[g];
    assign lowOk       = (maskedRid >= entBase[g]);
    assign highOk      = ({1'b0, maskedRid} < upperEx);
    assign entMatch[g] = entValid[g] && lowOk && highOk;
  end

  // Priority pick: lowest index wins (descending scan overwrites).
  logic             anyHit;
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (entMatch[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  logic [RID_W-1:0] specNext;
  assign specNext = maskedRid - entBase[selIdx] + entOut[selIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respHit    <= 1'b0;
      respTarget <= '0;
      respSpec   <= '0;
    end else if (strobe.lookup && anyHit) begin
      respHit    <= 1'b1;
      respTarget <= entTgt[selIdx];
      respSpec   <= specNext;
    end else begin
      respHit    <= 1'b0;
      respTarget <= '0;
      respSpec   <= '0;
    end
  end
endmodule

// File: rtl/rid_xlate.sv
module rid_xlate
  import rid_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RID_W       = 16,
  parameter int TGT_W       = 2,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaskWr,
  input  logic [RID_W-1:0] cfgMask,
  input  logic             cfgEntryWr,
  input  logic [IDX_W-1:0] cfgEntry,
  input  logic             cfgValid,
  input  logic [RID_W-1:0] cfgRidBase,
  input  logic [TGT_W-1:0] cfgTarget,
  input  logic [RID_W-1:0] cfgOutBase,
  input  logic [RID_W:0]   cfgLength,
  input  logic             reqValid,
  input  logic [RID_W-1:0] reqRid,
  output logic             respValid,
  output logic             respHit,
  output logic [TGT_W-1:0] respTarget,
  output logic [RID_W-1:0] respSpec
);
  xlateStrobe_t strobe;

  rid_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMaskWr  (cfgMaskWr),
    .cfgEntryWr (cfgEntryWr),
    .reqValid   (reqValid),
    .strobe     (strobe),
    .respValid  (respValid)
  );

  rid_xlate_dp #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .RID_W       (RID_W),
    .TGT_W       (TGT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgMask    (cfgMask),
    .cfgEntry   (cfgEntry),
    .cfgValid   (cfgValid),
    .cfgRidBase (cfgRidBase),
    .cfgTarget  (cfgTarget),
    .cfgOutBase (cfgOutBase),
    .cfgLength  (cfgLength),
    .reqRid     (reqRid),
    .respHit    (respHit),
    .respTarget (respTarget),
    .respSpec   (respSpec)
  );
endmodule

// File: rtl/rid_xlate_chk.sv
module rid_xlate_chk #(
  parameter int RID_W = 16,
  parameter int TGT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             respValid,
  input logic             respHit,
  input logic [TGT_W-1:0] respTarget,
  input logic [RID_W-1:0] respSpec
);
  // R8: every accepted request yields a result on the next cycle
  a_r8_req_gives_resp: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R8: no result without a request in the previous cycle
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  // R6: a miss carries zero target and zero specifier
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respSpec == '0 && respTarget == '0));

  // R8: idle outputs read zero
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && respSpec == '0 && respTarget == '0));
endmodule

bind rid_xlate rid_xlate_chk #(.RID_W(RID_W), .TGT_W(TGT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .respValid  (respValid),
  .respHit    (respHit),
  .respTarget (respTarget),
  .respSpec   (respSpec)
);

// File: tb/rid_xlate_tb_top.sv
`timescale 1ns/1ps
module rid_xlate_tb_top;
  localparam int N    = 4;
  localparam int RW   = 16;
  localparam int TW   = 2;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgMaskWr = 1'b0;
  logic [RW-1:0] cfgMask = '0;
  logic          cfgEntryWr = 1'b0;
  logic [IW-1:0] cfgEntry = '0;
  logic          cfgValid = 1'b0;
  logic [RW-1:0] cfgRidBase = '0;
  logic [TW-1:0] cfgTarget = '0;
  logic [RW-1:0] cfgOutBase = '0;
  logic [RW:0]   cfgLength = '0;
  logic          reqValid = 1'b0;
  logic [RW-1:0] reqRid = '0;
  logic          respValid;
  logic          respHit;
  logic [TW-1:0] respTarget;
  logic [RW-1:0] respSpec;

  always #5 clk = ~clk;

  rid_xlate #(.NUM_ENTRIES(N), .RID_W(RW), .TGT_W(TW)) dut_i (.*);

  int    nChecks = 0;
  int    nFails  = 0;
  string curTag  = "R1";
  bit    checkOn = 1'b0;

  // Behavioural reference model
  int    mMask;
  bit    mV   [N];
  int    mBase[N];
  int    mTgt [N];
  int    mOut [N];
  int    mLen [N];
  bit    expValid = 1'b0;
  bit    expHit   = 1'b0;
  int    expTgt   = 0;
  int    expSpec  = 0;
  string expTag   = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      mMask    = 'hFFFF;
      for (int i = 0; i < N; i++) mV[i] = 1'b0;
      expValid = 1'b0; expHit = 1'b0; expTgt = 0; expSpec = 0;
    end else begin
      int r;
      expValid = reqValid; expHit = 1'b0; expTgt = 0; expSpec = 0;
      expTag   = curTag;
      if (reqValid) begin
        r = int'(reqRid) & mMask;
        for (int i = 0; i < N; i++) begin
          if (!expHit && mV[i] && r >= mBase[i] && r < mBase[i] + mLen[i]) begin
            expHit  = 1'b1;
            expTgt  = mTgt[i];
            expSpec = (r - mBase[i] + mOut[i]) & 'hFFFF;
          end
        end
      end
      if (cfgMaskWr) mMask = int'(cfgMask);
      if (cfgEntryWr) begin
        mV[cfgEntry]    = cfgValid;
        mBase[cfgEntry] = int'(cfgRidBase);
        mTgt[cfgEntry]  = int'(cfgTarget);
        mOut[cfgEntry]  = int'(cfgOutBase);
        mLen[cfgEntry]  = int'(cfgLength);
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (checkOn) begin
      chk(expTag, "respValid", int'(respValid), int'(expValid));
      if (expValid) begin
        chk(expTag, "respHit",    int'(respHit),    int'(expHit));
        chk(expTag, "respTarget", int'(respTarget), expTgt);
        chk(expTag, "respSpec",   int'(respSpec),   expSpec);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    cfgMaskWr = 1'b0; cfgEntryWr = 1'b0; reqValid = 1'b0;
  endtask

  task automatic lookup(input logic [RW-1:0] rid);
    reqValid = 1'b1; reqRid = rid;
    tick();
  endtask

  task automatic setEntry(input int idx, input bit v, input int base, input int tgt,
                          input int ob, input int len);
    cfgEntryWr = 1'b1; cfgEntry = IW'(idx); cfgValid = v;
    cfgRidBase = RW'(base); cfgTarget = TW'(tgt); cfgOutBase = RW'(ob);
    cfgLength  = (RW+1)'(len);
  endtask

  task automatic writeEntry(input int idx, input bit v, input int base, input int tgt,
                            input int ob, input int len);
    setEntry(idx, v, base, tgt, ob, len);
    tick();
  endtask

  task automatic writeMask(input int m);
    cfgMaskWr = 1'b1; cfgMask = RW'(m);
    tick();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state at the ports
    chk("R1", "respValid after reset", int'(respValid), 0);
    chk("R1", "respHit after reset", int'(respHit), 0);
    chk("R1", "respSpec after reset", int'(respSpec), 0);
    checkOn = 1'b1;

    curTag = "R1"; lookup(16'h1234);               // empty table -> miss
    curTag = "R5"; writeEntry(0, 1, 0, 1, 0, 'h10000);
    curTag = "R1"; lookup(16'hABCF);               // reset mask passes all bits
    curTag = "R5"; lookup(16'hFFFF); lookup(16'h0000);
    curTag = "R2"; writeMask('hFFF8);
    lookup(16'hABCF); lookup(16'hABC8); lookup(16'h0107);
    writeMask('hFFFF);

    curTag = "R4";
    writeEntry(0, 1, 'h0000, 0, 'h8000, 'h8000);
    writeEntry(1, 1, 'h8000, 0, 'h0000, 'h8000);
    lookup(16'h0012); lookup(16'h8034); lookup(16'h7FFF); lookup(16'hFFFF);

    curTag = "R10";
    writeEntry(0, 1, 'h0000, 1, 0, 'h8000);
    writeEntry(1, 1, 'h8000, 2, 0, 'h8000);
    lookup(16'h7FFF); lookup(16'h8000); lookup(16'h4321); lookup(16'hC321);

    curTag = "R3";
    writeEntry(0, 1, 'h0100, 3, 'h0040, 'h10);
    writeEntry(1, 0, 0, 0, 0, 0);
    lookup(16'h00FF); lookup(16'h0100); lookup(16'h010F); lookup(16'h0110);

    curTag = "R5";
    writeEntry(2, 1, 'h0200, 1, 'h0055, 0);
    lookup(16'h0200); lookup(16'h01FF);

    curTag = "R7";
    writeEntry(0, 1, 'h0300, 1, 'h1000, 'h20);
    writeEntry(1, 1, 'h0310, 2, 'h2000, 'h20);
    lookup(16'h0315); lookup(16'h0325); lookup(16'h0305);

    curTag = "R6";
    writeEntry(0, 0, 'h0300, 1, 'h1000, 'h20);
    lookup(16'h0305); lookup(16'h0315);

    curTag = "R9";
    setEntry(3, 1, 'h0500, 3, 'h0700, 'h10);
    reqValid = 1'b1; reqRid = 16'h0500;
    tick();                                       // same-cycle write: old table
    lookup(16'h0500);                             // now visible
    cfgMaskWr = 1'b1; cfgMask = 16'h0000;
    reqValid = 1'b1; reqRid = 16'h0505;
    tick();                                       // mask change not yet seen
    lookup(16'h0505);                             // masked to 0 -> miss
    writeMask('hFFFF);

    curTag = "R8";
    writeEntry(0, 1, 'h0000, 1, 'h0003, 'h4000);
    writeEntry(1, 1, 'h4000, 2, 'h0000, 'h4000);
    writeEntry(2, 1, 'h8000, 0, 'h1111, 'h8000);
    for (int i = 0; i < 24; i++) begin
      if (i % 5 == 4) tick();
      else lookup(RW'(i * 'h1357 + 'h0A0B));
    end
    tick(); tick();
    finishRun();
  end
endmodule